// File: doc/BRIEF.md
# UART Receive Interrupt Flag Controller

This block sits between a UART character receiver and the interrupt fabric. It decides when the receiver's software-visible receive flag is raised and when an interrupt request goes out. Each completed character or detected line break arrives as a one-cycle strobe, together with its error bits and an address marker. The block then weighs that event against two software qualifiers. One lets erroneous characters through. The other restricts notification to address characters only.

Alongside the visible flag it keeps a hidden start-detect flag. A valid start bit sets that flag while start detection is enabled. Only withdrawing that enable, or a power-up reset, clears it. The single interrupt request line is active while either flag is set and the interrupt enable bit is 1. It comes from a register, so it is glitch-free and changes on the same clock edge as the flags it reflects.

A visible flag that is set while the request line stays low after the enable is withdrawn tells software that a character arrived. Software clears the flag by reading the buffer (`buf_rd`) or by acknowledging the interrupt (`irq_ack`).

Top module: `uart_rx_irq_ctl`

## Requirements
- R1: A character event carrying any error (parity, framing, break, or a break strobe) leaves `rx_flag` unchanged while `err_irq_en` is 0, whether the flag was 0 or 1.
- R2: With `err_irq_en` at 1, an erroneous character sets `rx_flag` on the next clock edge, provided the address qualifier of R3 passes.
- R3: With `addr_only_mode` at 0 every qualifying event sets `rx_flag`; with it at 1 only events with `addr_char` at 1 set it.
- R4: A `break_det` strobe counts as a received event that carries a break error, so it obeys R1, R2 and R3.
- R5: `buf_rd` or `irq_ack` clears `rx_flag` on the next edge; when a set event arrives in the same cycle, the flag ends up 1.
- R6: `soft_rst` at 1 clears `rx_flag` and `irq_en` on the next edge, overriding a set event and an enable write; it leaves the hidden start-detect flag untouched.
- R7: `rst` at 1 clears `rx_flag`, `irq_en`, the start-detect flag and `irq_req` on the next edge.
- R8: `start_valid` sets the hidden start-detect flag only while `start_det_en` is 1; `start_det_en` at 0 clears it; `buf_rd` and `irq_ack` do not affect it.
- R9: In every cycle after reset, `irq_req` equals (`rx_flag` OR start-detect flag) AND `irq_en`, all as held in registers, with no cycle of lag.
- R10: `ie_wr` at 1 loads `ie_wdata` into `irq_en` on the next edge unless `soft_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| soft_rst | input | 1 | Software reset bit, synchronous clear |
| char_done | input | 1 | One-cycle strobe: a character is in the buffer |
| break_det | input | 1 | One-cycle strobe: a line break was detected |
| err_parity | input | 1 | Parity error of the current character |
| err_frame | input | 1 | Framing error of the current character |
| err_break | input | 1 | Break error of the current character |
| addr_char | input | 1 | Current character is marked as an address |
| start_valid | input | 1 | One-cycle strobe: valid start bit seen |
| err_irq_en | input | 1 | Let erroneous characters set the flag |
| addr_only_mode | input | 1 | Only address characters set the flag |
| start_det_en | input | 1 | Start-detect enable; 0 clears the hidden flag |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_wdata | input | 1 | Value written to the interrupt enable |
| buf_rd | input | 1 | Receive buffer read strobe |
| irq_ack | input | 1 | Interrupt service acknowledge strobe |
| rx_flag | output | 1 | Software-visible receive flag |
| irq_en | output | 1 | Interrupt enable bit |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the power-up reset is held for at least one clock before any strobe matters. They also assume that the event qualifiers (`err_irq_en`, `addr_only_mode`) are stable during the cycle in which a `char_done` or `break_det` strobe is high. The hold and clear properties further assume that set events reach the flag only through the qualified path. Every strobe in the stimulus is driven at the falling edge and held for exactly one cycle. The mode bits change only between strobes, so each vector sees a settled qualifier set.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

    // Error bits attached to one received character
    typedef struct packed {
        logic parity;
        logic frame;
        logic brk;
    } rx_err_t;

    // One receive-side event as seen in a single cycle
    typedef struct packed {
        logic    done;
        logic    brk_det;
        logic    addr;
        rx_err_t err;
    } rx_event_t;

    // Software qualifiers for flag setting
    typedef struct packed {
        logic err_ie;
        logic addr_only;
    } rx_mode_t;

    // Next-state operation selected for the receive flag
    typedef enum logic [1:0] {
        FL_HOLD  = 2'd0,
        FL_SET   = 2'd1,
        FL_CLEAR = 2'd2
    } flag_op_t;

    function automatic logic ev_present(rx_event_t e);
        return e.done | e.brk_det;
    endfunction

    // A break strobe always implies a break error
    function automatic logic ev_has_error(rx_event_t e);
        return e.err.parity | e.err.frame | e.err.brk | e.brk_det;
    endfunction

    function automatic logic ev_addr_pass(rx_event_t e, rx_mode_t m);
        return !m.addr_only || e.addr;
    endfunction

    function automatic logic ev_err_pass(rx_event_t e, rx_mode_t m);
        return !ev_has_error(e) || m.err_ie;
    endfunction

endpackage

// File: rtl/rxirq_qualify.sv
module rxirq_qualify
    import rxirq_pkg::*;
(
    input  rx_event_t ev,
    input  rx_mode_t  mode,
    output logic      set_evt
);

    logic present;
    logic err_ok;
    logic addr_ok;

    always_comb begin
        present = ev_present(ev);
        err_ok  = ev_err_pass(ev, mode);
        addr_ok = ev_addr_pass(ev, mode);
        set_evt = present && err_ok && addr_ok;
    end

endmodule

// File: rtl/rxirq_flag.sv
module rxirq_flag
    import rxirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_evt,
    input  logic buf_rd,
    input  logic irq_ack,
    output logic flag_d,
    output logic flag_q
);

    flag_op_t op;

    // Set beats a same-cycle clear so no notification is dropped
    always_comb begin
        if (soft_rst)
            op = FL_CLEAR;
        else if (set_evt)
            op = FL_SET;
        else if (buf_rd || irq_ack)
            op = FL_CLEAR;
        else
            op = FL_HOLD;
    end

    always_comb begin
        case (op)
            FL_SET:   flag_d = 1'b1;
            FL_CLEAR: flag_d = 1'b0;
            default:  flag_d = flag_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= flag_d;
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (set_evt && !soft_rst) |=> flag_q);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ((buf_rd || irq_ack) && !set_evt && !soft_rst) |=> !flag_q);

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!set_evt && !buf_rd && !irq_ack && !soft_rst) |=> (flag_q == $past(flag_q)));

    p_soft_clr_r6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !flag_q);

endmodule

// File: rtl/rxirq_startdet.sv
module rxirq_startdet (
    input  logic clk,
    input  logic rst,
    input  logic start_en,
    input  logic start_valid,
    output logic sdet_d,
    output logic sdet_q
);

    always_comb begin
        if (!start_en)
            sdet_d = 1'b0;
        else if (start_valid)
            sdet_d = 1'b1;
        else
            sdet_d = sdet_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sdet_q <= 1'b0;
        else
            sdet_q <= sdet_d;
    end

    p_sdet_off_r8: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> !sdet_q);

    p_sdet_set_r8: assert property (@(posedge clk) disable iff (rst)
        (start_en && start_valid) |=> sdet_q);

endmodule

// File: rtl/rxirq_request.sv
module rxirq_request (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic ie_wr,
    input  logic ie_wdata,
    input  logic flag_d,
    input  logic sdet_d,
    output logic ie_q,
    output logic req_q
);

    logic ie_d;
    logic req_d;

    always_comb begin
        if (soft_rst)
            ie_d = 1'b0;
        else if (ie_wr)
            ie_d = ie_wdata;
        else
            ie_d = ie_q;
        // Built from next-state values so the request tracks the flags without lag
        req_d = (flag_d || sdet_d) && ie_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            ie_q  <= ie_d;
            req_q <= req_d;
        end
    end

    p_ie_soft_r6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !ie_q);

    p_ie_write_r10: assert property (@(posedge clk) disable iff (rst)
        (ie_wr && !soft_rst) |=> (ie_q == $past(ie_wdata)));

endmodule

// File: rtl/uart_rx_irq_ctl.sv
module uart_rx_irq_ctl
    import rxirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic char_done,
    input  logic break_det,
    input  logic err_parity,
    input  logic err_frame,
    input  logic err_break,
    input  logic addr_char,
    input  logic start_valid,
    input  logic err_irq_en,
    input  logic addr_only_mode,
    input  logic start_det_en,
    input  logic ie_wr,
    input  logic ie_wdata,
    input  logic buf_rd,
    input  logic irq_ack,
    output logic rx_flag,
    output logic irq_en,
    output logic irq_req
);

    rx_event_t ev;
    rx_mode_t  mode;
    logic      set_evt;
    logic      flag_d;
    logic      sdet_d;
    logic      sdet_q;

    always_comb begin
        ev.done       = char_done;
        ev.brk_det    = break_det;
        ev.addr       = addr_char;
        ev.err.parity = err_parity;
        ev.err.frame  = err_frame;
        ev.err.brk    = err_break;
        mode.err_ie    = err_irq_en;
        mode.addr_only = addr_only_mode;
    end

    rxirq_qualify u_qualify (
        .ev      (ev),
        .mode    (mode),
        .set_evt (set_evt)
    );

    rxirq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_evt  (set_evt),
        .buf_rd   (buf_rd),
        .irq_ack  (irq_ack),
        .flag_d   (flag_d),
        .flag_q   (rx_flag)
    );

    rxirq_startdet u_startdet (
        .clk         (clk),
        .rst         (rst),
        .start_en    (start_det_en),
        .start_valid (start_valid),
        .sdet_d      (sdet_d),
        .sdet_q      (sdet_q)
    );

    rxirq_request u_request (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .ie_wr    (ie_wr),
        .ie_wdata (ie_wdata),
        .flag_d   (flag_d),
        .sdet_d   (sdet_d),
        .ie_q     (irq_en),
        .req_q    (irq_req)
    );

    logic err_any;
    assign err_any = err_parity || err_frame || err_break || break_det;

    p_err_block_r1: assert property (@(posedge clk) disable iff (rst)
        (err_any && !err_irq_en && !rx_flag) |=> !rx_flag);

    p_addr_block_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_only_mode && !addr_char && !rx_flag) |=> !rx_flag);

    p_req_track_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req == ((rx_flag || sdet_q) && irq_en));

    p_por_r7: assert property (@(posedge clk)
        rst |=> (!rx_flag && !irq_en && !irq_req && !sdet_q));

endmodule

// File: tb/uart_rx_irq_ctl_tb.sv
module uart_rx_irq_ctl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0, char_done = 1'b0, break_det = 1'b0;
    logic err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
    logic addr_char = 1'b0, start_valid = 1'b0;
    logic err_irq_en = 1'b0, addr_only_mode = 1'b0, start_det_en = 1'b0;
    logic ie_wr = 1'b0, ie_wdata = 1'b0, buf_rd = 1'b0, irq_ack = 1'b0;
    logic rx_flag, irq_en, irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_rx_irq_ctl u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .char_done(char_done),
        .break_det(break_det), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .addr_char(addr_char), .start_valid(start_valid),
        .err_irq_en(err_irq_en), .addr_only_mode(addr_only_mode),
        .start_det_en(start_det_en), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .buf_rd(buf_rd), .irq_ack(irq_ack), .rx_flag(rx_flag),
        .irq_en(irq_en), .irq_req(irq_req)
    );

    // Vector bits, msb first:
    // soft_rst char_done break_det _ parity frame break _ addr_char start_valid _
    // err_irq_en addr_only_mode start_det_en _ ie_wr ie_wdata _ buf_rd irq_ack _
    // expected rx_flag irq_en irq_req
    localparam int NV = 30;
    localparam logic [17:0] VEC [NV] = '{
        18'b000_000_00_000_11_00_010, // R10 enable on
        18'b010_000_00_000_00_00_111, // R3 clean char sets
        18'b000_000_00_000_00_00_111, // R9 idle holds
        18'b000_000_00_000_00_10_010, // R5 read clears
        18'b010_100_00_000_00_00_010, // R1 parity err blocked
        18'b010_010_00_100_00_00_111, // R2 framing err passes
        18'b010_001_00_000_00_00_111, // R1 err char leaves set flag set
        18'b000_000_00_000_00_01_010, // R5 ack clears
        18'b010_000_00_010_00_00_010, // R3 non-address blocked
        18'b010_000_10_010_00_00_111, // R3 address passes
        18'b010_000_10_010_00_10_111, // R5 set beats read
        18'b010_000_10_010_00_01_111, // R5 set beats ack
        18'b000_000_00_000_00_01_010, // R5 ack clears
        18'b001_000_00_000_00_00_010, // R4 break blocked without err enable
        18'b001_000_00_100_00_00_111, // R4 break passes with err enable
        18'b000_000_00_000_00_10_010, // R5 read clears
        18'b001_000_00_110_00_00_010, // R4 break blocked in address mode
        18'b000_000_01_000_00_00_010, // R8 start ignored when disabled
        18'b000_000_01_001_00_00_011, // R8 start sets hidden flag
        18'b000_000_00_001_00_01_011, // R8 ack leaves hidden flag
        18'b000_000_00_001_00_10_011, // R8 read leaves hidden flag
        18'b000_000_00_000_00_00_010, // R8 disable clears hidden flag
        18'b010_000_00_000_10_00_100, // R10 enable off, R9 no request
        18'b000_000_00_000_11_00_111, // R9 request with pending flag
        18'b110_000_00_000_00_00_000, // R6 soft reset beats set
        18'b010_001_00_100_00_00_100, // R6 flag sets while enable stays 0
        18'b100_000_01_001_00_00_000, // R6 soft reset, start flag set
        18'b000_000_00_001_11_00_011, // R6 hidden flag kept through soft reset
        18'b000_000_00_000_00_00_010, // R8 disable clears
        18'b100_000_00_000_11_00_000  // R6 soft reset beats enable write
    };
    localparam int VREQ [NV] = '{10, 3, 9, 5, 1, 2, 1, 5, 3, 3, 5, 5, 5, 4, 4,
                                 5, 4, 8, 8, 8, 8, 8, 10, 9, 6, 6, 6, 6, 8, 6};

    task automatic check3(input int req, input logic [2:0] exp);
        n_checks++;
        if ({rx_flag, irq_en, irq_req} !== exp) begin
            n_fail++;
            $display("FAIL R%0d: flag/en/req actual %b%b%b expected %b",
                     req, rx_flag, irq_en, irq_req, exp);
        end
    endtask

    task automatic drive(input logic [14:0] v);
        {soft_rst, char_done, break_det, err_parity, err_frame, err_break,
         addr_char, start_valid, err_irq_en, addr_only_mode, start_det_en,
         ie_wr, ie_wdata, buf_rd, irq_ack} = v;
    endtask

    task automatic step(input logic [14:0] v, input int req, input logic [2:0] exp);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        check3(req, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check3(7, 3'b000);               // R7 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++)
            step(VEC[i][17:3], VREQ[i], VEC[i][2:0]);

        // R7: power-up reset clears all state mid-run
        step(15'b000_000_01_001_11_00, 7, 3'b011);
        step(15'b010_000_00_001_00_00, 7, 3'b111);
        rst = 1'b1;
        step(15'b000_000_00_001_00_00, 7, 3'b000);
        rst = 1'b0;
        // R7: enable again with start detect still on: hidden flag was cleared
        step(15'b000_000_00_001_11_00, 7, 3'b010);
        // R2/R3 erroneous address character in address mode with err enable
        step(15'b010_100_10_110_00_00, 2, 3'b111);
        // R9 read and ack together clear, request drops with flag
        step(15'b000_000_00_000_00_11, 9, 3'b010);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule